// File: doc/BRIEF.md
# Dual-Threshold Hit Acquisition Sequencer

This block sequences the capture of one pulse waveform. A low-threshold and a high-threshold discriminator feed it. A rising edge of the low-threshold pulse starts an acquisition. The block then latches the free-running time counter, counts the hit, and launches one of two alternating digitizers. It raises a coincidence launch in the same cycle, then waits for that digitizer to report completion. A high-threshold pulse seen shortly after the start means a larger signal. The first channel read is then the middle gain range instead of the most sensitive one. A saturation flag pushes the read one range further, up to the last one.

Two digitizers are used in turn, so that a new hit can be taken while the other unit is still busy converting or draining. Each written record carries the index of the unit that produced it, because the two units may be offset by one sample. When both units report busy, the hit is dropped. In photoelectron-counting mode the hit counter is compared against a threshold. When the count passes the threshold, a status bit is set and the count is cleared. A watchdog on the completion wait returns the sequencer to idle and flags an error.

Top module: `hit_acq_seq`

## Requirements
- R1: After reset the launch, coincidence, drop and write outputs are low, the hit count is 0, the read channel is 0 and both status bits are low.
- R2: An accepted low-threshold rising edge gives exactly one single-cycle launch pulse on one digitizer bit and a coincidence pulse in the same cycle, and increments the hit count by one.
- R3: The time stamp output holds the time counter value of the cycle before the launch pulse appears.
- R4: The first channel read is 1 if the synchronized high-threshold input was high at any point in the start cycle or the following WIN_CYC-1 cycles, and 0 otherwise.
- R5: While the saturation input is high during a read and the channel is below 2, the channel steps up by one. Channel 2 is written regardless of saturation.
- R6: The unit chosen is the one not used last, if its busy input is low. Otherwise the other unit is chosen. Unit 0 is preferred first after reset.
- R7: When both busy inputs are high at a start, there is no launch, the hit count does not change, and the drop output pulses for one cycle.
- R8: A start edge arriving while an acquisition is in progress is not counted and not launched, and it pulses the drop output.
- R9: After completion, the buffer write enable pulses for exactly one cycle. The read channel and the unit tag are valid in that cycle, and the sequencer is then ready for a new start.
- R10: In counting mode, the increment that would take the count above SPE_THR clears the count to 0 and sets the counting status bit, which holds until reset. Outside counting mode the count keeps increasing.
- R11: If completion is not seen within TMO_CYC cycles of waiting, the sequencer returns to idle without writing and sets the timeout status bit, which holds until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_lo_i | input | 1 | Low-threshold discriminator, asynchronous |
| disc_hi_i | input | 1 | High-threshold discriminator, asynchronous |
| count_mode_i | input | 1 | Photoelectron-counting mode enable |
| dig_busy_i | input | 2 | Per-digitizer busy |
| dig_done_i | input | 2 | Per-digitizer conversion complete |
| saturated_i | input | 1 | Saturation of the channel under read |
| time_i | input | TS_W | Free-running time counter |
| launch_o | output | 2 | Per-digitizer launch pulse |
| coinc_o | output | 1 | Coincidence launch pulse |
| drop_o | output | 1 | Start edge not taken |
| rd_chan_o | output | 2 | Channel being read or written |
| rd_unit_o | output | 1 | Unit tag of the current record |
| buf_we_o | output | 1 | Waveform buffer write enable |
| stamp_o | output | TS_W | Latched time stamp |
| hit_cnt_o | output | CNT_W | Hit count |
| spe_flag_o | output | 1 | Counting threshold passed |
| tmo_err_o | output | 1 | Completion timeout seen |

## Verification
The assertions assume that each digitizer raises done only after it has been launched. They also assume that a busy input reflects the previous cycle's unit state. The launch check compares against the busy value of the decision cycle. The bench raises done only on the unit it saw launched, and it changes busy only at least one cycle before a start edge. It drives saturation as a plain function of the channel presented, so each read cycle sees a stable value.

// File: rtl/hit_acq_pkg.sv
package hit_acq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } acq_state_e;

    localparam logic [1:0] TOP_CHAN = 2'd2;
endpackage

// File: rtl/disc_sync.sv
module disc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/unit_pick.sv
module unit_pick (
    input  logic       last_i,
    input  logic [1:0] busy_i,
    output logic       ok_o,
    output logic       unit_o
);
    logic pref;

    always_comb begin
        pref = ~last_i;
        if (!busy_i[pref]) begin
            ok_o   = 1'b1;
            unit_o = pref;
        end else if (!busy_i[~pref]) begin
            ok_o   = 1'b1;
            unit_o = ~pref;
        end else begin
            ok_o   = 1'b0;
            unit_o = pref;
        end
    end
endmodule

// File: rtl/hit_acq_seq.sv
module hit_acq_seq #(
    parameter int TS_W    = 48,
    parameter int CNT_W   = 16,
    parameter int SPE_THR = 3,
    parameter int WIN_CYC = 8,
    parameter int TMO_CYC = 1024,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_lo_i,
    input  logic             disc_hi_i,
    input  logic             count_mode_i,
    input  logic [1:0]       dig_busy_i,
    input  logic [1:0]       dig_done_i,
    input  logic             saturated_i,
    input  logic [TS_W-1:0]  time_i,
    output logic [1:0]       launch_o,
    output logic             coinc_o,
    output logic             drop_o,
    output logic [1:0]       rd_chan_o,
    output logic             rd_unit_o,
    output logic             buf_we_o,
    output logic [TS_W-1:0]  stamp_o,
    output logic [CNT_W-1:0] hit_cnt_o,
    output logic             spe_flag_o,
    output logic             tmo_err_o
);
    import hit_acq_pkg::*;

    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam int TMO_W = $clog2(TMO_CYC);
    localparam logic [WIN_W-1:0] WIN_END  = WIN_W'(WIN_CYC);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] THR      = CNT_W'(SPE_THR);

    typedef struct packed {
        acq_state_e       state;
        logic             unit;
        logic             last;
        logic             hi_seen;
        logic [WIN_W-1:0] win;
        logic [TMO_W-1:0] tmo;
        logic [1:0]       chan;
        logic [TS_W-1:0]  stamp;
        logic [CNT_W-1:0] hits;
        logic             spe;
        logic             err;
        logic [1:0]       launch;
        logic             coinc;
        logic             drop;
        logic             we;
    } acq_regs_t;

    acq_regs_t r_q, r_d;

    // conditioned discriminators: index 0 = low, 1 = high
    logic [1:0] disc_raw, disc_lvl, disc_rise;
    assign disc_raw = {disc_hi_i, disc_lo_i};

    for (genvar g = 0; g < 2; g++) begin : g_disc
        disc_sync #(.STAGES(SYNC_ST)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (disc_raw[g]),
            .level_o (disc_lvl[g]),
            .rise_o  (disc_rise[g])
        );
    end

    logic pick_ok, pick_unit;

    unit_pick u_pick (
        .last_i (r_q.last),
        .busy_i (dig_busy_i),
        .ok_o   (pick_ok),
        .unit_o (pick_unit)
    );

    logic [CNT_W-1:0] hits_inc;
    assign hits_inc = r_q.hits + CNT_W'(1);

    always_comb begin
        r_d        = r_q;
        r_d.launch = 2'b00;
        r_d.coinc  = 1'b0;
        r_d.drop   = 1'b0;
        r_d.we     = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (disc_rise[0]) begin
                    if (pick_ok) begin
                        r_d.state   = ST_WAIT;
                        r_d.unit    = pick_unit;
                        r_d.last    = pick_unit;
                        r_d.stamp   = time_i;
                        r_d.launch  = pick_unit ? 2'b10 : 2'b01;
                        r_d.coinc   = 1'b1;
                        r_d.hi_seen = disc_lvl[1];
                        r_d.win     = WIN_W'(1);
                        r_d.tmo     = '0;
                        if (count_mode_i && (hits_inc > THR)) begin
                            r_d.hits = '0;
                            r_d.spe  = 1'b1;
                        end else begin
                            r_d.hits = hits_inc;
                        end
                    end else begin
                        r_d.drop = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                r_d.drop = disc_rise[0];
                if (r_q.win < WIN_END) begin
                    r_d.hi_seen = r_q.hi_seen | disc_lvl[1];
                    r_d.win     = r_q.win + WIN_W'(1);
                end
                if (dig_done_i[r_q.unit]) begin
                    r_d.state = ST_READ;
                    r_d.chan  = r_d.hi_seen ? 2'd1 : 2'd0;
                end else if (r_q.tmo == TMO_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.tmo = r_q.tmo + TMO_W'(1);
                end
            end
            ST_READ: begin
                r_d.drop = disc_rise[0];
                if (saturated_i && (r_q.chan != TOP_CHAN)) begin
                    r_d.chan = r_q.chan + 2'd1;
                end else begin
                    r_d.state = ST_WRITE;
                    r_d.we    = 1'b1;
                end
            end
            ST_WRITE: begin
                r_d.drop  = disc_rise[0];
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.last  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign launch_o   = r_q.launch;
    assign coinc_o    = r_q.coinc;
    assign drop_o     = r_q.drop;
    assign rd_chan_o  = r_q.chan;
    assign rd_unit_o  = r_q.unit;
    assign buf_we_o   = r_q.we;
    assign stamp_o    = r_q.stamp;
    assign hit_cnt_o  = r_q.hits;
    assign spe_flag_o = r_q.spe;
    assign tmo_err_o  = r_q.err;
endmodule

// File: rtl/hit_acq_seq_chk.sv
module hit_acq_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       dig_busy_i,
    input logic             saturated_i,
    input logic [1:0]       launch_o,
    input logic             coinc_o,
    input logic             drop_o,
    input logic [1:0]       rd_chan_o,
    input logic             buf_we_o,
    input logic [CNT_W-1:0] hit_cnt_o,
    input logic             spe_flag_o,
    input logic             tmo_err_o
);
    assert_launch_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch_o));

    assert_coinc_with_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coinc_o |-> $countones(launch_o) == 1);

    assert_launch_free_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o[0] |-> !$past(dig_busy_i[0]));

    assert_launch_free_unit1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o[1] |-> !$past(dig_busy_i[1]));

    assert_no_launch_and_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> launch_o == 2'b00);

    assert_chan_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> rd_chan_o <= 2'd2);

    assert_low_chan_unsaturated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we_o && rd_chan_o != 2'd2) |-> !$past(saturated_i));

    assert_we_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |=> !buf_we_o);

    assert_spe_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spe_flag_o |=> spe_flag_o);

    assert_tmo_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |=> tmo_err_o);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!coinc_o && !spe_flag_o) |-> hit_cnt_o == $past(hit_cnt_o) || $past(!rst_n));
endmodule

bind hit_acq_seq hit_acq_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dig_busy_i  (dig_busy_i),
    .saturated_i (saturated_i),
    .launch_o    (launch_o),
    .coinc_o     (coinc_o),
    .drop_o      (drop_o),
    .rd_chan_o   (rd_chan_o),
    .buf_we_o    (buf_we_o),
    .hit_cnt_o   (hit_cnt_o),
    .spe_flag_o  (spe_flag_o),
    .tmo_err_o   (tmo_err_o)
);

// File: tb/hit_acq_seq_tb.sv
`timescale 1ns/1ps
module hit_acq_seq_tb;
    localparam int TS_W  = 48;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             disc_lo_i = 1'b0, disc_hi_i = 1'b0, count_mode_i = 1'b0;
    logic [1:0]       dig_busy_i = 2'b00, dig_done_i = 2'b00;
    logic             saturated_i;
    logic [TS_W-1:0]  time_i = '0;
    logic [1:0]       launch_o, rd_chan_o;
    logic             coinc_o, drop_o, rd_unit_o, buf_we_o, spe_flag_o, tmo_err_o;
    logic [TS_W-1:0]  stamp_o;
    logic [CNT_W-1:0] hit_cnt_o;
    logic [2:0]       sat_mask = 3'b000;

    int total = 0, bad = 0;
    int n_launch = 0, n_drop = 0, n_we = 0, n_coinc_mis = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) time_i <= time_i + 1'b1;
    assign saturated_i = sat_mask[rd_chan_o];

    always @(negedge clk) begin
        if (launch_o != 2'b00) n_launch++;
        if ((launch_o != 2'b00) != coinc_o) n_coinc_mis++;
        if (drop_o) n_drop++;
        if (buf_we_o) n_we++;
    end

    hit_acq_seq u_dut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one acquisition; returns observed launch unit, write channel/unit
    task automatic acquire(input bit hi_early, input bit hi_late, input bit relo,
                           input bit give_done, input logic [1:0] busy,
                           output bit launched, output bit unit,
                           output bit wrote, output logic [1:0] wchan, output bit wunit);
        logic [TS_W-1:0] exp_stamp;
        launched = 0; unit = 0; wrote = 0; wchan = 0; wunit = 0;
        @(negedge clk);
        dig_busy_i = busy;
        @(negedge clk);
        disc_lo_i = 1'b1;
        disc_hi_i = hi_early;
        for (int i = 0; i < 10 && !launched; i++) begin
            @(negedge clk);
            if (launch_o != 2'b00) begin
                launched  = 1;
                unit      = launch_o[1];
                exp_stamp = time_i - 1'b1;
                check(stamp_o == exp_stamp, "R3 stamp", stamp_o, exp_stamp);
            end
        end
        repeat (2) @(negedge clk);
        disc_lo_i = 1'b0;
        disc_hi_i = 1'b0;
        dig_busy_i = 2'b00;
        if (!launched) begin
            repeat (10) @(negedge clk);
            return;
        end
        repeat (6) @(negedge clk);
        if (relo) disc_lo_i = 1'b1;
        if (hi_late) disc_hi_i = 1'b1;
        repeat (3) @(negedge clk);
        disc_lo_i = 1'b0;
        disc_hi_i = 1'b0;
        repeat (10) @(negedge clk);
        if (!give_done) return;
        dig_done_i[unit] = 1'b1;
        @(negedge clk);
        dig_done_i = 2'b00;
        for (int i = 0; i < 10 && !wrote; i++) begin
            @(negedge clk);
            if (buf_we_o) begin
                wrote = 1; wchan = rd_chan_o; wunit = rd_unit_o;
            end
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(launch_o == 0 && !coinc_o && !drop_o && !buf_we_o, "R1 pulses idle", {launch_o, coinc_o, drop_o, buf_we_o}, 0);
        check(hit_cnt_o == 0, "R1 hit count", hit_cnt_o, 0);
        check(rd_chan_o == 0 && !spe_flag_o && !tmo_err_o, "R1 status", {rd_chan_o, spe_flag_o, tmo_err_o}, 0);
    endtask

    task automatic t_count_mode();
        bit l, u, w, wu; logic [1:0] c;
        do_reset();
        count_mode_i = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            acquire(0, 0, 0, 1, 2'b00, l, u, w, c, wu);
        end
        check(hit_cnt_o == 3 && !spe_flag_o, "R10 below threshold", {hit_cnt_o, spe_flag_o}, {16'd3, 1'b0});
        acquire(0, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(hit_cnt_o == 0, "R10 count cleared", hit_cnt_o, 0);
        check(spe_flag_o == 1'b1, "R10 flag set", spe_flag_o, 1);
        count_mode_i = 1'b0;
    endtask

    task automatic t_basic_and_pingpong();
        bit l, u, w, wu; logic [1:0] c; int nl;
        do_reset();
        nl = n_launch;
        acquire(0, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(n_launch == nl + 1 && n_coinc_mis == 0, "R2 one launch with coinc", n_launch - nl, 1);
        check(hit_cnt_o == 1, "R2 count", hit_cnt_o, 1);
        check(u == 0, "R6 first unit", u, 0);
        check(w && c == 0 && wu == 0, "R4 R9 low only chan0", {w, c, wu}, {1'b1, 2'd0, 1'b0});
        acquire(1, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(u == 1, "R6 alternate", u, 1);
        check(w && c == 1 && wu == 1, "R4 both chan1 tag", {w, c, wu}, {1'b1, 2'd1, 1'b1});
        acquire(0, 1, 0, 1, 2'b01, l, u, w, c, wu);
        check(u == 1, "R6 preferred busy", u, 1);
        check(w && c == 0, "R4 late high ignored", c, 0);
        check(hit_cnt_o == 3, "R2 count grows without mode", hit_cnt_o, 3);
    endtask

    task automatic t_saturation();
        bit l, u, w, wu; logic [1:0] c;
        sat_mask = 3'b001;
        acquire(0, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(w && c == 1, "R5 step 0 to 1", c, 1);
        sat_mask = 3'b111;
        acquire(0, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(w && c == 2, "R5 cap at 2", c, 2);
        sat_mask = 3'b110;
        acquire(1, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(w && c == 2, "R5 from 1", c, 2);
        sat_mask = 3'b000;
    endtask

    task automatic t_drops();
        bit l, u, w, wu; logic [1:0] c; int nd, nl; logic [CNT_W-1:0] hc;
        nd = n_drop; nl = n_launch; hc = hit_cnt_o;
        acquire(0, 0, 0, 1, 2'b11, l, u, w, c, wu);
        check(!l && n_launch == nl, "R7 no launch both busy", n_launch - nl, 0);
        check(hit_cnt_o == hc && n_drop == nd + 1, "R7 drop no count", {hit_cnt_o, 16'(n_drop - nd)}, {hc, 16'd1});
        nd = n_drop;
        acquire(0, 0, 1, 1, 2'b00, l, u, w, c, wu);
        check(hit_cnt_o == hc + 1 && n_drop == nd + 1, "R8 ignored restart", {hit_cnt_o, 16'(n_drop - nd)}, {16'(hc + 1), 16'd1});
        check(w, "R9 write after ignored restart", w, 1);
    endtask

    task automatic t_timeout();
        bit l, u, w, wu; logic [1:0] c; int nw;
        nw = n_we;
        check(!tmo_err_o, "R11 clear before", tmo_err_o, 0);
        acquire(0, 0, 0, 0, 2'b00, l, u, w, c, wu);
        repeat (1100) @(negedge clk);
        check(tmo_err_o && n_we == nw, "R11 timeout no write", {tmo_err_o, 8'(n_we - nw)}, {1'b1, 8'd0});
        acquire(0, 0, 0, 1, 2'b00, l, u, w, c, wu);
        check(l && w && tmo_err_o, "R11 back to idle, flag held", {l, w, tmo_err_o}, 3'b111);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_count_mode();
        t_basic_and_pingpong();
        t_saturation();
        t_drops();
        t_timeout();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule